// File: doc/BRIEF.md
# Windowed PCI Configuration Address Translator

This block sits between a big-endian CPU bus and a PCI configuration-access engine. It claims CPU reads and writes of one, two or four bytes that fall inside a fixed 4 MiB window. Every claimed access is turned into a type-0 configuration request. The device number comes from a one-hot select bit in the CPU address. The function number and the register dword come from the lower address bits. Data of two- and four-byte accesses is byte-reversed in both directions, so a big-endian CPU sees the little-endian configuration space in its own byte order.

A single finite-state machine runs each access. **IDLE** waits for a claimed request. On acceptance it moves *IDLE→ISSUE* for a legal access, or *IDLE→REPLY* for an illegal size or alignment. **ISSUE** presents the request downstream until the engine takes it. It moves *ISSUE→REPLY* for a write and *ISSUE→WAIT_DATA* for a read. **WAIT_DATA** waits for returned data and moves *WAIT_DATA→REPLY* when it arrives. **REPLY** pulses the CPU response for one cycle and moves *REPLY→IDLE*. Only one access is in flight at a time.

Top module: `cfgx_xlate`

## Requirements
- R1: The window covers addresses 0x8080_0000 to 0x80BF_FFFF. An address outside it never sees `cpu_req_ready` high and starts no downstream request and no response.
- R2: The device number in `cfg_addr[15:11]` is the index (0..10) of the lowest set bit among CPU address bits 11..21, counting from bit 11.
- R3: When none of address bits 11..21 is set, the device number is 11.
- R4: `cfg_addr` has bit 31 set, bits 10:8 equal to address bits 10:8, bits 7:2 equal to address bits 7:2, and every other bit zero. The word is formed anew from each accepted access.
- R5: `cfg_lane` carries address bits 1:0 and `cfg_size` carries the size code. The size codes are 0 = one byte, 1 = two bytes, 2 = four bytes and 3 = reserved.
- R6: Write data is forwarded as follows. A one-byte write passes it unchanged. A two-byte write sends {16'h0, wdata[7:0], wdata[15:8]}. A four-byte write sends all four bytes in reverse order.
- R7: Read data returned downstream reaches `cpu_rsp_rdata` with the same size-dependent byte reordering as in R6.
- R8: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid` stays high and the address, lane, size, direction and write data hold stable.
- R9: `cpu_rsp_valid` is a one-cycle pulse. For a write it comes in the cycle after the downstream handshake. For a read it comes in the cycle after `cfg_rvalid`, with `cpu_rsp_err` low.
- R10: A two-byte access with address bit 0 set, or a four-byte access with address bits 1:0 not zero, is not forwarded. It gets a response in the cycle after acceptance with `cpu_rsp_err` high and rdata zero.
- R11: An access with the reserved size code 3 is rejected in the same way as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Request accepted this cycle (idle and in window) |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | CPU physical address |
| cpu_req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 reserved |
| cpu_req_wdata | input | 32 | CPU write data (big-endian order) |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_err | output | 1 | Completion reports a rejected access |
| cpu_rsp_rdata | output | 32 | Read data in CPU byte order |
| cfg_valid | output | 1 | Configuration request present |
| cfg_ready | input | 1 | Engine takes the request |
| cfg_write | output | 1 | Request direction |
| cfg_addr | output | 32 | Type-0 configuration address word |
| cfg_lane | output | 2 | Byte offset within the dword |
| cfg_size | output | 2 | Size code |
| cfg_wdata | output | 32 | Write data in bus byte order |
| cfg_rvalid | input | 1 | Engine returns read data |
| cfg_rdata | input | 32 | Read data in bus byte order |

## Verification
The request appears on the downstream port in the cycle after the CPU handshake, because the state register and the captured fields add one register stage. The CPU response follows one cycle after the downstream handshake for a write. For a read it follows one cycle after `cfg_rvalid`. For a rejected access it follows one cycle after acceptance. The bench drives inputs just after a rising edge and samples every output at the falling edge of the exact cycle that this count predicts. In every intermediate cycle it confirms that no response is present and that a held request has not changed.

// File: rtl/cfgx_pkg.sv
`timescale 1ns/1ps
package cfgx_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } cfgx_size_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ISSUE     = 2'd1,
        ST_WAIT_DATA = 2'd2,
        ST_REPLY     = 2'd3
    } cfgx_state_e;

    // Rejects a reserved size and any unaligned half or word.
    function automatic logic access_illegal(input logic [1:0] sz, input logic [1:0] lane);
        logic r;
        r = 1'b0;
        if (sz == SZ_RSVD) r = 1'b1;
        if (sz == SZ_HALF && lane[0]) r = 1'b1;
        if (sz == SZ_WORD && lane != 2'b00) r = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/cfgx_idsel_enc.sv
`timescale 1ns/1ps
module cfgx_idsel_enc #(
    parameter int N = 11,
    parameter int W = $clog2(N + 1)
) (
    input  logic [N-1:0] sel,
    output logic [W-1:0] dev
);
    // Lowest set bit wins; nothing set maps to N.
    always_comb begin
        dev = W'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (sel[i]) dev = W'(i);
        end
    end
endmodule

// File: rtl/cfgx_word_build.sv
`timescale 1ns/1ps
module cfgx_word_build #(
    parameter int          AW       = 32,
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_LOG2 = 22,
    parameter int          SEL_LO   = 11,
    parameter int          SEL_N    = 11
) (
    input  logic [AW-1:2] addr,
    output logic          in_window,
    output logic [31:0]   word
);
    localparam int DEV_W = $clog2(SEL_N + 1);

    logic [DEV_W-1:0] dev;

    cfgx_idsel_enc #(.N(SEL_N), .W(DEV_W)) u_enc (
        .sel (addr[SEL_LO +: SEL_N]),
        .dev (dev)
    );

    assign in_window = (addr[AW-1:WIN_LOG2] == WIN_BASE[AW-1:WIN_LOG2]);

    always_comb begin
        word        = '0;
        word[31]    = 1'b1;
        word[15:11] = 5'(dev);
        word[10:8]  = addr[10:8];
        word[7:2]   = addr[7:2];
    end
endmodule

// File: rtl/cfgx_lane_swap.sv
`timescale 1ns/1ps
module cfgx_lane_swap #(
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    import cfgx_pkg::*;
    localparam int NB = DW / 8;

    logic [DW-1:0] rev;

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_rev
            assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
        end
    endgenerate

    always_comb begin
        dout = din;
        unique case (size)
            SZ_BYTE: dout = din;
            SZ_HALF: begin
                dout       = '0;
                dout[15:0] = {din[7:0], din[15:8]};
            end
            SZ_WORD: dout = rev;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/cfgx_xlate.sv
`timescale 1ns/1ps
module cfgx_xlate #(
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_LOG2 = 22,
    parameter int          SEL_LO   = 11,
    parameter int          SEL_N    = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    output logic        cpu_req_ready,
    input  logic        cpu_req_write,
    input  logic [31:0] cpu_req_addr,
    input  logic [1:0]  cpu_req_size,
    input  logic [31:0] cpu_req_wdata,
    output logic        cpu_rsp_valid,
    output logic        cpu_rsp_err,
    output logic [31:0] cpu_rsp_rdata,
    output logic        cfg_valid,
    input  logic        cfg_ready,
    output logic        cfg_write,
    output logic [31:0] cfg_addr,
    output logic [1:0]  cfg_lane,
    output logic [1:0]  cfg_size,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_rvalid,
    input  logic [31:0] cfg_rdata
);
    import cfgx_pkg::*;

    cfgx_state_e state, state_nx;

    logic        in_window;
    logic [31:0] new_word;
    logic [31:0] wdata_sw;
    logic [31:0] rdata_sw;
    logic        accept;
    logic        illegal;

    logic        q_write;
    logic [31:0] q_word;
    logic [1:0]  q_lane;
    logic [1:0]  q_size;
    logic [31:0] q_wdata;
    logic [31:0] q_rdata;
    logic        q_err;

    cfgx_word_build #(
        .AW(32), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
        .SEL_LO(SEL_LO), .SEL_N(SEL_N)
    ) u_word (
        .addr      (cpu_req_addr[31:2]),
        .in_window (in_window),
        .word      (new_word)
    );

    cfgx_lane_swap #(.DW(32)) u_wswap (
        .size (cpu_req_size),
        .din  (cpu_req_wdata),
        .dout (wdata_sw)
    );

    cfgx_lane_swap #(.DW(32)) u_rswap (
        .size (q_size),
        .din  (cfg_rdata),
        .dout (rdata_sw)
    );

    assign cpu_req_ready = (state == ST_IDLE) && in_window;
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign illegal       = access_illegal(cpu_req_size, cpu_req_addr[1:0]);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (accept) state_nx = illegal ? ST_REPLY : ST_ISSUE;
            ST_ISSUE:     if (cfg_ready) state_nx = q_write ? ST_REPLY : ST_WAIT_DATA;
            ST_WAIT_DATA: if (cfg_rvalid) state_nx = ST_REPLY;
            ST_REPLY:     state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Captured access fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_word  <= '0;
            q_lane  <= '0;
            q_size  <= '0;
            q_wdata <= '0;
            q_rdata <= '0;
            q_err   <= 1'b0;
        end else begin
            if (accept) begin
                q_write <= cpu_req_write;
                q_word  <= new_word;
                q_lane  <= cpu_req_addr[1:0];
                q_size  <= cpu_req_size;
                q_wdata <= wdata_sw;
                q_rdata <= '0;
                q_err   <= illegal;
            end else if (state == ST_WAIT_DATA && cfg_rvalid) begin
                q_rdata <= rdata_sw;
            end
        end
    end

    // Outputs
    always_comb begin
        cfg_valid     = 1'b0;
        cpu_rsp_valid = 1'b0;
        cpu_rsp_err   = 1'b0;
        cpu_rsp_rdata = '0;
        unique case (state)
            ST_ISSUE: cfg_valid = 1'b1;
            ST_REPLY: begin
                cpu_rsp_valid = 1'b1;
                cpu_rsp_err   = q_err;
                cpu_rsp_rdata = q_rdata;
            end
            default: ;
        endcase
    end

    assign cfg_write = q_write;
    assign cfg_addr  = q_word;
    assign cfg_lane  = q_lane;
    assign cfg_size  = q_size;
    assign cfg_wdata = q_wdata;

    p_no_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_addr[31:WIN_LOG2] != WIN_BASE[31:WIN_LOG2]) |-> !cpu_req_ready);

    p_word_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_addr[31] && cfg_addr[30:16] == '0 && cfg_addr[1:0] == 2'b00));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_addr) && $stable(cfg_wdata)
                                       && $stable(cfg_lane) && $stable(cfg_size) && $stable(cfg_write)));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    p_read_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_DATA && cfg_rvalid) |=> (cpu_rsp_valid && !cpu_rsp_err));

    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && illegal) |=> (cpu_rsp_valid && cpu_rsp_err && !cfg_valid));
endmodule

// File: tb/cfgx_xlate_tb_top.sv
`timescale 1ns/1ps
module cfgx_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [1:0]  cpu_req_size = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic        cpu_rsp_err;
    logic [31:0] cpu_rsp_rdata;
    logic        cfg_valid;
    logic        cfg_ready = 1'b0;
    logic        cfg_write;
    logic [31:0] cfg_addr;
    logic [1:0]  cfg_lane;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic        cfg_rvalid = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cfgx_xlate dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        int dev;
        dev = 11;
        for (int i = 10; i >= 0; i--) if (a[11 + i]) dev = i;
        return 32'h8000_0000 | (32'(dev) << 11) | ({29'd0, a[10:8]} << 8) | (a & 32'h0000_00FC);
    endfunction

    function automatic logic [31:0] exp_swap(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd1) return {16'h0, d[7:0], d[15:8]};
        if (sz == 2'd2) return {d[7:0], d[15:8], d[23:16], d[31:24]};
        return d;
    endfunction

    task automatic access(input string tag, input logic wr, input logic [31:0] a,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input int rdy_dly, input int rd_dly, input logic [31:0] raw);
        bit bad;
        bad = (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
        @(posedge clk); #1;
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
        cpu_req_size = sz; cpu_req_wdata = wd;
        @(negedge clk);
        check("R1 ready in window", 32'(cpu_req_ready), 32'd1);
        @(posedge clk); #1;
        cpu_req_valid = 1'b0;
        @(negedge clk);
        if (bad) begin
            check(sz == 2'd3 ? "R11 rsvd rsp" : "R10 misalign rsp", 32'(cpu_rsp_valid), 32'd1);
            check(sz == 2'd3 ? "R11 rsvd err" : "R10 misalign err", 32'(cpu_rsp_err), 32'd1);
            check("R10 no forward", 32'(cfg_valid), 32'd0);
            check("R10 rdata zero", cpu_rsp_rdata, 32'd0);
            @(negedge clk);
            check("R10 no forward later", 32'(cfg_valid), 32'd0);
            return;
        end
        check({tag, " word"}, cfg_addr, exp_word(a));
        check("R5 lane", 32'(cfg_lane), 32'(a[1:0]));
        check("R5 size", 32'(cfg_size), 32'(sz));
        check("R4 valid", 32'(cfg_valid), 32'd1);
        check("R4 dir", 32'(cfg_write), 32'(wr));
        if (wr) check("R6 wdata", cfg_wdata, exp_swap(sz, wd));
        for (int k = 0; k < rdy_dly; k++) begin
            @(negedge clk);
            check("R8 held valid", 32'(cfg_valid), 32'd1);
            check("R8 held word", cfg_addr, exp_word(a));
            check("R8 no rsp", 32'(cpu_rsp_valid), 32'd0);
        end
        cfg_ready = 1'b1;
        @(posedge clk); #1;
        cfg_ready = 1'b0;
        if (!wr) begin
            for (int k = 0; k < rd_dly; k++) begin
                @(negedge clk);
                check("R9 read waits", 32'(cpu_rsp_valid), 32'd0);
                check("R8 dropped after take", 32'(cfg_valid), 32'd0);
            end
            @(negedge clk);
            cfg_rvalid = 1'b1; cfg_rdata = raw;
            @(posedge clk); #1;
            cfg_rvalid = 1'b0; cfg_rdata = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        check("R9 rsp pulse", 32'(cpu_rsp_valid), 32'd1);
        check("R9 rsp no err", 32'(cpu_rsp_err), 32'd0);
        if (!wr) check("R7 rdata", cpu_rsp_rdata, exp_swap(sz, raw));
        @(negedge clk);
        check("R9 pulse ends", 32'(cpu_rsp_valid), 32'd0);
    endtask

    task automatic outside(input logic [31:0] a);
        @(posedge clk); #1;
        cpu_req_valid = 1'b1; cpu_req_addr = a; cpu_req_size = 2'd2; cpu_req_write = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 not claimed", 32'(cpu_req_ready), 32'd0);
            check("R1 no request", 32'(cfg_valid), 32'd0);
            check("R1 no response", 32'(cpu_rsp_valid), 32'd0);
        end
        @(posedge clk); #1;
        cpu_req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset rsp", 32'(cpu_rsp_valid), 32'd0);
        check("R8 reset cfg", 32'(cfg_valid), 32'd0);

        outside(32'h8000_0000);
        outside(32'h80C0_0000);
        outside(32'h807F_FFFC);

        access("R2 dev0",  1'b1, 32'h8080_0B10, 2'd2, 32'h1122_3344, 2, 0, '0);
        access("R2 dev10", 1'b0, 32'h80A0_0004, 2'd2, '0, 0, 1, 32'hA1B2_C3D4);
        access("R2 dev2",  1'b0, 32'h8080_A5FA, 2'd1, '0, 1, 3, 32'h0000_5566);
        access("R3 dev11", 1'b1, 32'h8080_0723, 2'd0, 32'h0000_00AB, 0, 0, '0);
        access("R4 half",  1'b1, 32'h8081_0042, 2'd1, 32'h0000_BEEF, 1, 0, '0);
        access("R4 byte",  1'b0, 32'h8080_4101, 2'd0, '0, 0, 0, 32'h0000_0077);
        access("R4 again", 1'b0, 32'h8082_0ABC, 2'd2, '0, 3, 2, 32'h0102_0304);
        access("R10 half", 1'b1, 32'h8080_0801, 2'd1, 32'h1234, 0, 0, '0);
        access("R10 word", 1'b0, 32'h8080_0802, 2'd2, '0, 0, 0, '0);
        access("R11 rsvd", 1'b0, 32'h8080_0800, 2'd3, '0, 0, 0, '0);
        access("R2 after", 1'b1, 32'h8080_1000, 2'd2, 32'hCAFE_F00D, 0, 0, '0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule